// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits between a group of maskable interrupt request lines and a CPU core. Each source owns a sticky pending flag, a mask bit and a two-bit priority level. The block also holds the global interrupt-enable bit and the level currently in service. It picks one winner among the eligible sources and, after a fixed settle window, raises a one-cycle acknowledge. With that strobe it gives the winner's vector index, clears the global enable and raises the in-service level to the winner's level.

The request lines are asynchronous and pass through a synchronizer. A rising edge on a synchronized line sets that source's pending flag. Software reaches the flag, mask, priority and enable registers through a small write port. A return-from-interrupt pulse pops the enable bit and in-service level that were saved when the interrupt was taken. The save stack holds one entry per priority level, so every legal nesting depth fits.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A source can be taken only while its pending flag is 1 and its mask bit is 0. A masked source's flag stays set and shows on `pend_o`.
- R2: No acknowledge is given while the global enable `ie_o` is 0. Eligible requests wait until it is set.
- R3: A source is taken only if its level is numerically below `isp_o`, that is strictly higher in priority. A source at an equal or lower level stays pending.
- R4: Among the takeable sources, the lowest level value wins. On a tie, the lowest source index wins.
- R5: A pending request is acknowledged without being raised again once it becomes takeable. This applies when it is unmasked, when the enable is set, or when a return lowers the in-service level.
- R6: On acknowledge, `ie_o` becomes 0, `isp_o` becomes the winner's level and the winner's pending flag is cleared. All of these show in the same cycle as the strobe.
- R7: `ack_o` is a single-cycle pulse, and in that cycle `vec_o` carries the winner's source index.
- R8: With default parameters, a request edge that meets an idle, enabled controller is acknowledged 9 to 16 cycles after the first clock edge that samples it. The nominal value is 11.
- R9: A `reti_i` pulse restores `ie_o` and `isp_o` to the values saved at the matching acknowledge. Nesting is last-in first-out, up to 4 levels deep. A pulse with nothing saved changes nothing.
- R10: A rising edge on a request line sets the pending flag after two synchronizer stages. A held level does not set the flag again.
- R11: Register writes use `wr_addr_i`: 0 writes all pending flags from `wr_data_i[7:0]`, 1 writes the mask bits, 2 writes the levels (source i at bits 2i+1:2i), and 3 writes the enable from bit 0.
- R12: After reset, `ack_o`=0, `ie_o`=0, `pend_o`=0, every source is masked, every level is 3, and `isp_o`=4. The value 4 means nothing is in service, and levels 0..3 all beat it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_SRC | Asynchronous request lines, rising edge sets pending |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select (0 pending, 1 mask, 2 levels, 3 enable) |
| wr_data_i | input | NUM_SRC*LVL_W | Write data |
| reti_i | input | 1 | Return-from-interrupt pulse |
| ack_o | output | 1 | One-cycle service start strobe |
| vec_o | output | log2(NUM_SRC) | Winner index, valid with ack_o |
| ie_o | output | 1 | Global interrupt enable |
| isp_o | output | LVL_W+1 | In-service level, 4 when idle |
| pend_o | output | NUM_SRC | Pending flags |

## Verification
Some properties are checked on every cycle:
- An acknowledge only follows a cycle with the enable set.
- Each acknowledge leaves the enable clear and strictly raises the in-service priority.
- A return with saved state restores exactly the popped entry.
- The save stack never takes a push when full.
- A synchronized edge always leaves its flag set.

Other behaviours appear only in the bench's scenarios:
- Which source wins under mixed levels and masks.
- The latency window.
- That held-back requests are released at the right moment: after unmasking, after enabling, and after a return lowers the level.
- That a return with nothing saved leaves the state untouched.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  typedef enum logic {ST_IDLE, ST_WAIT} ctl_state_t;
  localparam logic [1:0] RA_PEND = 2'd0;
  localparam logic [1:0] RA_MASK = 2'd1;
  localparam logic [1:0] RA_PRIO = 2'd2;
  localparam logic [1:0] RA_CTRL = 2'd3;
endpackage

// File: rtl/irq_src_regs.sv
module irq_src_regs
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int LVL_W       = 2,
  parameter int SYNC_STAGES = 2,
  localparam int DATA_W     = NUM_SRC * LVL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [NUM_SRC-1:0] ack_clr_i,
  output logic [NUM_SRC-1:0] flags_o,
  output logic [NUM_SRC-1:0] mask_o,
  output logic [DATA_W-1:0]  prio_o
);
  logic [SYNC_STAGES-1:0][NUM_SRC-1:0] sync_q;
  logic [NUM_SRC-1:0] prev_q, edge_v, flags_q, mask_q;
  logic [DATA_W-1:0]  prio_q;

  assign edge_v = sync_q[SYNC_STAGES-1] & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= req_i;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      mask_q  <= '1;
      prio_q  <= '1;
    end else begin
      if (wr_en_i && wr_addr_i == RA_MASK) mask_q <= wr_data_i[NUM_SRC-1:0];
      if (wr_en_i && wr_addr_i == RA_PRIO) prio_q <= wr_data_i;
      // write, then acknowledge clear, then a fresh edge (last wins)
      flags_q <= (((wr_en_i && wr_addr_i == RA_PEND) ? wr_data_i[NUM_SRC-1:0] : flags_q)
                  & ~ack_clr_i) | edge_v;
    end
  end

  assign flags_o = flags_q;
  assign mask_o  = mask_q;
  assign prio_o  = prio_q;

  // R10
  edge_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (|edge_v) |=> ((flags_q & $past(edge_v)) == $past(edge_v)));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NUM_SRC = 8,
  parameter int LVL_W   = 2,
  localparam int IDX_W  = $clog2(NUM_SRC),
  localparam int DATA_W = NUM_SRC * LVL_W
) (
  input  logic [NUM_SRC-1:0] flags_i,
  input  logic [NUM_SRC-1:0] mask_i,
  input  logic [DATA_W-1:0]  prio_i,
  input  logic [LVL_W:0]     isp_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   win_o,
  output logic [LVL_W-1:0]   lvl_o
);
  logic [NUM_SRC-1:0] elig;

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++)
      elig[i] = flags_i[i] && !mask_i[i] && ({1'b0, prio_i[i*LVL_W +: LVL_W]} < isp_i);
  end

  // ascending scan with strict compare keeps the lowest index on ties
  always_comb begin
    any_o = 1'b0;
    win_o = '0;
    lvl_o = '1;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && (!any_o || prio_i[i*LVL_W +: LVL_W] < lvl_o)) begin
        any_o = 1'b1;
        win_o = IDX_W'(i);
        lvl_o = prio_i[i*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/irq_save_stack.sv
module irq_save_stack #(
  parameter int DEPTH = 4,
  parameter int W     = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] push_data_i,
  output logic [W-1:0] top_o,
  output logic         empty_o,
  output logic         full_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] sp_q;

  assign empty_o = (sp_q == '0);
  assign full_o  = (sp_q == PW'(DEPTH));
  assign top_o   = empty_o ? '0 : mem[AW'(sp_q - 1'b1)];

  always_ff @(posedge clk) begin
    if (push_i && !full_o) mem[AW'(sp_q)] <= push_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) sp_q <= '0;
    else if (push_i && !full_o) sp_q <= sp_q + 1'b1;
    else if (pop_i && !empty_o) sp_q <= sp_q - 1'b1;
  end

  // R9
  stack_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    push_i |-> !full_o);
  // R9
  stack_no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    pop_i |-> !empty_o);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int LVL_W       = 2,
  parameter int SYNC_STAGES = 2,
  parameter int WAIT_CYC    = 8,
  localparam int IDX_W      = $clog2(NUM_SRC),
  localparam int DATA_W     = NUM_SRC * LVL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               reti_i,
  output logic               ack_o,
  output logic [IDX_W-1:0]   vec_o,
  output logic               ie_o,
  output logic [LVL_W:0]     isp_o,
  output logic [NUM_SRC-1:0] pend_o
);
  localparam int              STK_DEPTH = 2 ** LVL_W;
  localparam int              STK_W     = LVL_W + 2;
  localparam int              CNT_W     = $clog2(WAIT_CYC + 1);
  localparam logic [LVL_W:0]  ISP_IDLE  = (LVL_W + 1)'(STK_DEPTH);

  ctl_state_t          state_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                ie_q, ack_q;
  logic [LVL_W:0]      isp_q;
  logic [IDX_W-1:0]    vec_q;
  logic [NUM_SRC-1:0]  flags, mask, ack_clr;
  logic [DATA_W-1:0]   prio;
  logic                any_elig, do_ack, do_pop, stk_empty, stk_full;
  logic [IDX_W-1:0]    win;
  logic [LVL_W-1:0]    win_lvl;
  logic [STK_W-1:0]    stk_top;

  irq_src_regs #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .SYNC_STAGES(SYNC_STAGES)) u_regs (
    .clk(clk), .rst(rst), .req_i(req_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .ack_clr_i(ack_clr), .flags_o(flags), .mask_o(mask), .prio_o(prio));

  irq_arbiter #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_arb (
    .flags_i(flags), .mask_i(mask), .prio_i(prio), .isp_i(isp_q),
    .any_o(any_elig), .win_o(win), .lvl_o(win_lvl));

  assign do_ack  = (state_q == ST_WAIT) && (cnt_q == '0) && !reti_i && ie_q && any_elig;
  assign do_pop  = reti_i && !stk_empty;
  assign ack_clr = do_ack ? (NUM_SRC'(1) << win) : '0;

  irq_save_stack #(.DEPTH(STK_DEPTH), .W(STK_W)) u_stk (
    .clk(clk), .rst(rst), .push_i(do_ack), .pop_i(do_pop), .push_data_i({ie_q, isp_q}),
    .top_o(stk_top), .empty_o(stk_empty), .full_o(stk_full));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ie_q    <= 1'b0;
      isp_q   <= ISP_IDLE;
      ack_q   <= 1'b0;
      vec_q   <= '0;
    end else begin
      ack_q <= 1'b0;
      if (wr_en_i && wr_addr_i == RA_CTRL) ie_q <= wr_data_i[0];
      case (state_q)
        ST_IDLE: if (ie_q && any_elig) begin
          state_q <= ST_WAIT;
          cnt_q   <= CNT_W'(WAIT_CYC - 1);
        end
        ST_WAIT: begin
          if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
          else if (!reti_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
      if (do_pop) begin
        ie_q  <= stk_top[STK_W-1];
        isp_q <= stk_top[LVL_W:0];
      end
      if (do_ack) begin
        ack_q <= 1'b1;
        vec_q <= win;
        ie_q  <= 1'b0;
        isp_q <= {1'b0, win_lvl};
      end
    end
  end

  assign ack_o  = ack_q;
  assign vec_o  = vec_q;
  assign ie_o   = ie_q;
  assign isp_o  = isp_q;
  assign pend_o = flags;

  // R2
  ack_needs_ie_chk: assert property (@(posedge clk) disable iff (rst)
    ack_q |-> $past(ie_q));
  // R6
  ack_clears_ie_chk: assert property (@(posedge clk) disable iff (rst)
    ack_q |-> (!ie_q && isp_q != ISP_IDLE));
  // R3
  ack_raises_level_chk: assert property (@(posedge clk) disable iff (rst)
    ack_q |-> (isp_q < $past(isp_q)));
  // R7
  ack_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ack_q |=> !ack_q);
  // R9
  reti_restore_chk: assert property (@(posedge clk) disable iff (rst)
    (reti_i && !stk_empty) |=> ({ie_q, isp_q} == $past(stk_top)));
  // R9
  stack_room_chk: assert property (@(posedge clk) disable iff (rst)
    do_ack |-> !stk_full);
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  localparam int N = 8;
  localparam int DW = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic [N-1:0] req = '0;
  logic wr_en = 1'b0, reti = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic ack, ie;
  logic [2:0] vec, isp;
  logic [N-1:0] pend;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst(rst), .req_i(req), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .reti_i(reti), .ack_o(ack), .vec_o(vec), .ie_o(ie),
    .isp_o(isp), .pend_o(pend));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reti();
    @(negedge clk);
    reti = 1'b1;
    @(negedge clk);
    reti = 1'b0;
  endtask

  // drive lines s from a negedge; count posedges after the sampling edge
  task automatic drive(input logic [N-1:0] s, input int lim, output bit got,
                       output int lat, output int v);
    got = 1'b0; lat = 0; v = -1;
    @(negedge clk);
    req = s;
    @(posedge clk);
    for (int c = 1; c <= lim; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (c == 2) req = '0;
      if (ack && !got) begin
        got = 1'b1; lat = c; v = int'(vec);
        break;
      end
    end
    req = '0;
  endtask

  function automatic int exp_win(input logic [N-1:0] s, input logic [N-1:0] m,
                                 input logic [DW-1:0] p);
    int best = -1, bl = 4;
    for (int i = 0; i < N; i++)
      if (s[i] && !m[i] && int'(p[2*i +: 2]) < bl) begin
        best = i; bl = int'(p[2*i +: 2]);
      end
    return best;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    bit got; int lat, v;
    logic [DW-1:0] pr;
    logic [N-1:0] mk, s;
    void'($urandom(32'h1CE5_0DD5));

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ack == 0 && ie == 0 && pend == 0, "R12 reset ack/ie/pend", int'(pend), 0);
    chk(isp == 3'd4, "R12 reset isp idle", int'(isp), 4);

    // levels: src0=1 src1=2 src2=0, others 3
    pr = 16'hFFFF; pr[1:0] = 2'd1; pr[3:2] = 2'd2; pr[5:4] = 2'd0;
    wr(2'd2, pr);
    wr(2'd3, 16'h1);
    drive(8'h08, 30, got, lat, v);
    chk(!got, "R1 masked source not taken (R12 reset mask)", int'(got), 0);
    chk(pend[3] == 1'b1, "R1 masked flag stays pending", int'(pend[3]), 1);
    wr(2'd1, 16'h00F7);
    drive(8'h00, 40, got, lat, v);
    chk(got && v == 3, "R5 unmasked pending taken, R7 vector", v, 3);
    chk(isp == 3'd3 && ie == 0 && pend[3] == 0, "R6 level/enable/flag on ack", int'(isp), 3);
    do_reti();
    @(negedge clk);
    chk(ie == 1 && isp == 3'd4, "R9 return restores", int'(isp), 4);

    wr(2'd3, 16'h0);
    wr(2'd1, 16'h0);
    drive(8'h10, 30, got, lat, v);
    chk(!got && pend[4], "R2 enable off holds request", int'(got), 0);
    wr(2'd3, 16'h1);
    drive(8'h00, 40, got, lat, v);
    chk(got && v == 4, "R2 R5 taken after enable set", v, 4);
    do_reti();

    drive(8'h01, 40, got, lat, v);
    chk(got && v == 0, "R10 edge sets flag and is taken", v, 0);
    chk(lat >= 9 && lat <= 16, "R8 latency window", lat, 11);
    chk(isp == 3'd1, "R6 isp takes winner level", int'(isp), 1);
    wr(2'd3, 16'h1);
    drive(8'h02, 30, got, lat, v);
    chk(!got && pend[1], "R3 lower level stays pending", int'(got), 0);
    drive(8'h04, 40, got, lat, v);
    chk(got && v == 2 && isp == 3'd0, "R3 higher level nests", v, 2);
    chk(lat >= 9 && lat <= 16, "R8 nested latency", lat, 11);
    do_reti();
    @(negedge clk);
    chk(isp == 3'd1 && ie == 1, "R9 nested return", int'(isp), 1);
    drive(8'h00, 20, got, lat, v);
    chk(!got && pend[1], "R3 equal-or-lower still pending", int'(got), 0);
    do_reti();
    drive(8'h00, 40, got, lat, v);
    chk(got && v == 1 && isp == 3'd2, "R5 taken after level drops", v, 1);
    do_reti();
    @(negedge clk);
    chk(isp == 3'd4 && ie == 1, "R9 outer return", int'(isp), 4);
    do_reti();
    @(negedge clk);
    chk(isp == 3'd4 && ie == 1 && !ack, "R9 empty return no effect", int'(isp), 4);

    wr(2'd2, 16'h5555);
    drive(8'h60, 40, got, lat, v);
    chk(got && v == 5, "R4 tie goes to lowest index", v, 5);
    wr(2'd0, 16'h0);
    @(negedge clk);
    chk(pend == 0, "R11 pending write clears flags", int'(pend), 0);
    do_reti();

    for (int it = 0; it < 40; it++) begin
      int k, e;
      wr(2'd3, 16'h0);
      wr(2'd0, 16'h0);
      pr = DW'($urandom);
      mk = N'($urandom);
      s  = N'($urandom);
      k  = int'($urandom_range(N - 1));
      s[k] = 1'b1; mk[k] = 1'b0;
      wr(2'd1, {8'h00, mk});
      wr(2'd2, pr);
      wr(2'd3, 16'h1);
      e = exp_win(s, mk, pr);
      drive(s, 40, got, lat, v);
      chk(got && v == e, "R4 random winner", v, e);
      chk(lat >= 9 && lat <= 16, "R8 random latency", lat, 11);
      chk(int'(isp) == int'(pr[2*e +: 2]) && !ie && !pend[e], "R6 random ack state",
          int'(isp), int'(pr[2*e +: 2]));
      wr(2'd0, 16'h0);
      do_reti();
      @(negedge clk);
      chk(isp == 3'd4 && ie, "R9 random return", int'(isp), 4);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule